// File: doc/BRIEF.md
# Pause Frame Receive and Transmit Hold Timer

This block sits on the receive side of a full-duplex Ethernet MAC and watches the received byte stream for flow-control requests. It accepts a frame as a pause request only when four things hold. The destination address must be the station's own or the reserved multicast group. The type and opcode must mark a pause operation. The frame must arrive without a receive error. Priority flow control must not be in force. When all of these hold, the block takes the 16-bit pause quantum that follows the opcode. It uses that quantum to stop the local transmitter from starting new frames.

The hold starts as soon as a quantum is loaded. The count does not begin until the transmitter reports idle. From then on the count drops by one on every 512-bit-time tick, or on every clock when the test setting is on. Two interrupt pulses come out of the block: one for each accepted pause request, and one when a pause period ends. A pause period ends either when the count reaches zero or when a zero-quantum request arrives. A saturating counter records how many pause requests were accepted.

The parser is a four-state machine: `PS_IDLE` (between frames), `PS_HEAD` (header bytes 0 to 16), `PS_TAIL` (quantum complete, waiting for the end beat) and `PS_DROP` (frame spoiled by an error, waiting for its end). Its transitions are as follows. A start beat enters `PS_HEAD` from any state; an error beat goes to `PS_DROP`; byte 17 moves to `PS_TAIL`; an end beat returns to `PS_IDLE`. The timer is a three-state machine: `TS_IDLE` (transmit free), `TS_DRAIN` (quantum loaded, current transmission finishing) and `TS_COUNT` (counting down). Its transitions are as follows. A nonzero load in full duplex goes to `TS_DRAIN` from any state. A zero load in full duplex goes to `TS_IDLE`. `TS_DRAIN` moves to `TS_COUNT` when the transmitter is idle. `TS_COUNT` returns to `TS_IDLE` on the step that takes the count from 1 to 0.

Top module: `pause_rx_timer`

## Requirements
- R1: A frame is accepted only if its first six bytes equal `station_addr` (bits 47:40 first on the wire) or the bytes 01 80 C2 00 00 01; any other destination leaves all outputs unchanged.
- R2: Bytes 12..13 must be 88 08 and bytes 14..15 must be 00 01; bytes 16..17 carry the quantum, high byte first.
- R3: A frame with `rx_err` set on any of its beats is discarded with no effect.
- R4: When `cfg_pfc_on` is high on the end beat, the frame is discarded with no effect.
- R5: A frame whose end beat comes before byte 17 is discarded. A start beat before the end beat abandons the partial frame, and parsing restarts from byte 0.
- R6: For each accepted frame, `irq_pause_rx` pulses for one cycle, one clock after the end beat, in both duplex modes.
- R7: In full duplex, a nonzero quantum raises `tx_hold` two clocks after the end beat. In half duplex the timer is not loaded and `tx_hold` is unaffected.
- R8: The count does not move while `tx_busy` is high. Once it is low, the count drops on each `slot_tick`, or on every clock when `cfg_test_step` is high. With the test setting on and `tx_busy` low, `tx_hold` is high for exactly quantum+1 cycles.
- R9: `irq_pause_expired` pulses when the count reaches zero, which is the cycle `tx_hold` falls. It also pulses two clocks after the end beat of an accepted zero-quantum frame, and that frame clears any hold in full duplex. The pulse is suppressed while `irq_expired_en` is low.
- R10: A newly accepted quantum replaces any count or hold already in progress.
- R11: `pause_rx_count` rises by one, two clocks after the end beat, for each accepted frame, and it stays at its maximum value once reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive/transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_err | input | 1 | Receive or FCS error reported with this beat |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Station unicast address, bits 47:40 first on the wire |
| cfg_full_duplex | input | 1 | Full-duplex mode enables timer loading |
| cfg_pfc_on | input | 1 | Priority flow control negotiated; pause frames ignored |
| cfg_test_step | input | 1 | Test mode: count down every clock |
| irq_expired_en | input | 1 | Mask for the expiry interrupt |
| tx_busy | input | 1 | Transmitter is sending a frame |
| slot_tick | input | 1 | One-cycle pulse every 512 bit times |
| tx_hold | output | 1 | Inhibit start of new transmit frames |
| irq_pause_rx | output | 1 | Accepted pause frame pulse |
| irq_pause_expired | output | 1 | Pause period ended pulse (masked) |
| pause_rx_count | output | CNT_W | Saturating count of accepted pause frames |

## Verification
Every result is tied to the end beat of a frame, driven before clock edge E0. The receive interrupt is due right after E0. The counter, the hold flag and the expiry pulse for a zero quantum are due after E1. The bench samples on the falling edge that follows each of those edges. With the test setting on and the transmitter idle, the hold lasts quantum+1 falling-edge samples, starting with the sample after E1. The expiry pulse must be present on the first sample where the hold is low. When the transmitter is busy, the run of hold samples is counted from the sample at which `tx_busy` is dropped, and the expected length is the same.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;

    localparam int QUANT_W   = 16;
    localparam int IDX_W     = 5;
    localparam int DA_BYTES  = 6;
    localparam int CTL_FIRST = 12;
    localparam int CTL_LAST  = 15;
    localparam int Q_HI_POS  = 16;
    localparam int Q_LO_POS  = 17;
    localparam int IDX_CAP   = 18;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_HEAD,
        PS_TAIL,
        PS_DROP
    } parse_state_e;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_DRAIN,
        TS_COUNT
    } timer_state_e;

    // Reserved flow-control group address, wire order.
    function automatic logic [7:0] group_da_byte(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return 8'h01;
            5'd1:    return 8'h80;
            5'd2:    return 8'hC2;
            5'd5:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Type 0x8808 followed by opcode 0x0001.
    function automatic logic [7:0] ctl_byte(input logic [IDX_W-1:0] i);
        case (i)
            5'd12:   return 8'h88;
            5'd13:   return 8'h08;
            5'd15:   return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return a[47:40];
            5'd1:    return a[39:32];
            5'd2:    return a[31:24];
            5'd3:    return a[23:16];
            5'd4:    return a[15:8];
            default: return a[7:0];
        endcase
    endfunction

endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
    import pause_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_err,
    input  logic [7:0]         rx_data,
    input  logic [47:0]        station_addr,
    input  logic               cfg_pfc_on,
    output logic               evt_valid,
    output logic [QUANT_W-1:0] evt_quant
);

    parse_state_e       state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic               sta_ok_q, grp_ok_q, ctl_ok_q;
    logic [QUANT_W-1:0] quant_q;

    logic               in_frame, take_beat;
    logic [IDX_W-1:0]   cur_idx, idx_n;
    logic               sta_ok_n, grp_ok_n, ctl_ok_n;
    logic [QUANT_W-1:0] quant_n;
    logic               accept;

    always_comb begin
        in_frame  = (state_q == PS_HEAD) || (state_q == PS_TAIL);
        take_beat = rx_valid && (rx_sof || in_frame);
        cur_idx   = rx_sof ? '0 : idx_q;
        idx_n     = (cur_idx >= IDX_W'(IDX_CAP)) ? IDX_W'(IDX_CAP) : cur_idx + 1'b1;

        sta_ok_n = rx_sof ? 1'b1 : sta_ok_q;
        grp_ok_n = rx_sof ? 1'b1 : grp_ok_q;
        ctl_ok_n = rx_sof ? 1'b1 : ctl_ok_q;
        quant_n  = quant_q;

        if (cur_idx < IDX_W'(DA_BYTES)) begin
            sta_ok_n = sta_ok_n && (rx_data == addr_byte(station_addr, cur_idx));
            grp_ok_n = grp_ok_n && (rx_data == group_da_byte(cur_idx));
        end
        if (cur_idx >= IDX_W'(CTL_FIRST) && cur_idx <= IDX_W'(CTL_LAST)) begin
            ctl_ok_n = ctl_ok_n && (rx_data == ctl_byte(cur_idx));
        end
        if (cur_idx == IDX_W'(Q_HI_POS)) quant_n[15:8] = rx_data;
        if (cur_idx == IDX_W'(Q_LO_POS)) quant_n[7:0]  = rx_data;

        accept = take_beat && rx_eof && !rx_err && !cfg_pfc_on
                 && (cur_idx >= IDX_W'(Q_LO_POS))
                 && (sta_ok_n || grp_ok_n) && ctl_ok_n;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (rx_valid) begin
            if (take_beat) begin
                if (rx_err)
                    state_d = rx_eof ? PS_IDLE : PS_DROP;
                else if (rx_eof)
                    state_d = PS_IDLE;
                else if (cur_idx >= IDX_W'(Q_LO_POS))
                    state_d = PS_TAIL;
                else
                    state_d = PS_HEAD;
            end else begin
                unique case (state_q)
                    PS_DROP: state_d = rx_eof ? PS_IDLE : PS_DROP;
                    PS_IDLE: state_d = PS_IDLE;
                    default: state_d = state_q;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            sta_ok_q  <= 1'b0;
            grp_ok_q  <= 1'b0;
            ctl_ok_q  <= 1'b0;
            quant_q   <= '0;
            evt_valid <= 1'b0;
            evt_quant <= '0;
        end else begin
            evt_valid <= accept;
            if (accept) evt_quant <= quant_n;
            if (take_beat) begin
                idx_q    <= idx_n;
                sta_ok_q <= sta_ok_n;
                grp_ok_q <= grp_ok_n;
                ctl_ok_q <= ctl_ok_n;
                quant_q  <= quant_n;
            end
        end
    end

endmodule

// File: rtl/pause_hold_timer.sv
module pause_hold_timer
    import pause_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_evt,
    input  logic [QUANT_W-1:0] load_quant,
    input  logic               cfg_full_duplex,
    input  logic               cfg_test_step,
    input  logic               tx_busy,
    input  logic               slot_tick,
    output logic               hold,
    output logic               expire_pulse
);

    timer_state_e       state_q, state_d;
    logic [QUANT_W-1:0] cnt_q;
    logic               step, fd_load, zero_q, last_step;

    always_comb begin
        step      = cfg_test_step || slot_tick;
        fd_load   = load_evt && cfg_full_duplex;
        zero_q    = (load_quant == '0);
        last_step = (state_q == TS_COUNT) && step && (cnt_q == QUANT_W'(1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (fd_load) begin
            state_d = zero_q ? TS_IDLE : TS_DRAIN;
        end else begin
            unique case (state_q)
                TS_IDLE:  state_d = TS_IDLE;
                TS_DRAIN: state_d = tx_busy ? TS_DRAIN : TS_COUNT;
                TS_COUNT: state_d = last_step ? TS_IDLE : TS_COUNT;
                default:  state_d = TS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    // Count and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            expire_pulse <= 1'b0;
        end else begin
            expire_pulse <= (load_evt && zero_q) || (last_step && !fd_load);
            if (fd_load)
                cnt_q <= load_quant;
            else if ((state_q == TS_COUNT) && step)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign hold = (state_q != TS_IDLE);

endmodule

// File: rtl/sat_event_counter.sv
module sat_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  value <= '0;
        else if (inc && value != TOP) value <= value + 1'b1;
    end

endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer
    import pause_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic [7:0]       rx_data,
    input  logic [47:0]      station_addr,
    input  logic             cfg_full_duplex,
    input  logic             cfg_pfc_on,
    input  logic             cfg_test_step,
    input  logic             irq_expired_en,
    input  logic             tx_busy,
    input  logic             slot_tick,
    output logic             tx_hold,
    output logic             irq_pause_rx,
    output logic             irq_pause_expired,
    output logic [CNT_W-1:0] pause_rx_count
);

    logic               evt_valid;
    logic [QUANT_W-1:0] evt_quant;
    logic               expire_raw;

    pause_frame_parser u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_err       (rx_err),
        .rx_data      (rx_data),
        .station_addr (station_addr),
        .cfg_pfc_on   (cfg_pfc_on),
        .evt_valid    (evt_valid),
        .evt_quant    (evt_quant)
    );

    pause_hold_timer u_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .load_evt        (evt_valid),
        .load_quant      (evt_quant),
        .cfg_full_duplex (cfg_full_duplex),
        .cfg_test_step   (cfg_test_step),
        .tx_busy         (tx_busy),
        .slot_tick       (slot_tick),
        .hold            (tx_hold),
        .expire_pulse    (expire_raw)
    );

    sat_event_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt_valid),
        .value (pause_rx_count)
    );

    assign irq_pause_rx      = evt_valid;
    assign irq_pause_expired = expire_raw && irq_expired_en;

endmodule

// File: rtl/pause_rx_timer_chk.sv
module pause_rx_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_full_duplex,
    input logic             irq_expired_en,
    input logic             tx_hold,
    input logic             irq_pause_rx,
    input logic             irq_pause_expired,
    input logic [CNT_W-1:0] pause_rx_count
);

    // R6
    rx_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pause_rx |=> !irq_pause_rx);

    // R9
    expired_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_expired_en |-> !irq_pause_expired);

    // R9
    hold_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_hold) && irq_expired_en) |-> irq_pause_expired);

    // R7
    half_duplex_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_full_duplex && !tx_hold) |=> !tx_hold);

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pause_rx |=> ((pause_rx_count == $past(pause_rx_count) + 1'b1) || (&pause_rx_count)));

    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pause_rx |=> $stable(pause_rx_count));

endmodule

bind pause_rx_timer pause_rx_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_full_duplex   (cfg_full_duplex),
    .irq_expired_en    (irq_expired_en),
    .tx_hold           (tx_hold),
    .irq_pause_rx      (irq_pause_rx),
    .irq_pause_expired (irq_pause_expired),
    .pause_rx_count    (pause_rx_count)
);

// File: tb/test_pause_rx_timer.sv
module test_pause_rx_timer;

    localparam int CW = 3;
    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] GRP = 48'h01_80_C2_00_00_01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
    logic [7:0] rx_data = '0;
    logic fd = 1, pfc = 0, tst = 1, msk = 1, busy = 0, tick = 0;
    logic tick_en = 0;
    logic tx_hold, irq_rx, irq_exp;
    logic [CW-1:0] cnt;

    int checks = 0, errors = 0;
    int exp_cnt = 0;
    bit got_rx, got_exp, got_hold;
    int got_cnt;
    int tick_div = 0;

    always #10 clk = ~clk;

    pause_rx_timer #(.CNT_W(CW)) i_pause_rx_timer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .rx_data(rx_data),
        .station_addr(STA), .cfg_full_duplex(fd), .cfg_pfc_on(pfc),
        .cfg_test_step(tst), .irq_expired_en(msk), .tx_busy(busy),
        .slot_tick(tick), .tx_hold(tx_hold), .irq_pause_rx(irq_rx),
        .irq_pause_expired(irq_exp), .pause_rx_count(cnt));

    always @(negedge clk) begin
        if (tick_en) begin
            tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
            tick <= (tick_div == 3);
        end else begin
            tick_div <= 0;
            tick <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [47:0] da, input logic [15:0] ty,
                                         input logic [15:0] op, input logic [15:0] q, input int i);
        if (i < 6)       return da[47-8*i -: 8];
        else if (i < 12) return 8'hA0 + 8'(i);
        else if (i == 12) return ty[15:8];
        else if (i == 13) return ty[7:0];
        else if (i == 14) return op[15:8];
        else if (i == 15) return op[7:0];
        else if (i == 16) return q[15:8];
        else if (i == 17) return q[7:0];
        else             return 8'h00;
    endfunction

    // Drives len bytes starting at frame offset off; with fin, marks the end and
    // samples results after E0 (rx irq) and after E1 (count, hold, expiry).
    task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                        input logic [15:0] q, input int len, input int err_at,
                        input int off, input bit fin);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = fin && (i == len - 1);
            rx_err = (i == err_at); rx_data = fbyte(da, ty, op, q, i + off);
        end
        if (fin) begin
            @(negedge clk);
            got_rx = irq_rx;
            rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
            @(negedge clk);
            got_exp = irq_exp; got_hold = tx_hold; got_cnt = int'(cnt);
        end
    endtask

    task automatic pause(input logic [47:0] da, input logic [15:0] q);
        send(da, 16'h8808, 16'h0001, q, 60, -1, 0, 1);
    endtask

    function automatic int bump(input int c);
        return (c == (1 << CW) - 1) ? c : c + 1;
    endfunction

    task automatic measure(output int n, output bit seen);
        n = 0;
        while (tx_hold && n < 5000) begin n++; @(negedge clk); end
        seen = irq_exp;
    endtask

    task automatic expect_none(input string req);
        chk(got_rx == 0, req, got_rx, 0);
        chk(got_cnt == exp_cnt, req, got_cnt, exp_cnt);
        chk(got_hold == 0, req, got_hold, 0);
    endtask

    task automatic t_reset;
        chk(tx_hold == 0 && irq_rx == 0 && irq_exp == 0, "reset", tx_hold, 0);
        chk(cnt == 0, "reset R11", int'(cnt), 0);
    endtask

    task automatic t_group_fd;
        int n; bit seen;
        pause(GRP, 16'd5);
        exp_cnt = bump(exp_cnt);
        chk(got_rx == 1, "R6", got_rx, 1);
        chk(got_cnt == exp_cnt, "R11", got_cnt, exp_cnt);
        chk(got_hold == 1, "R7", got_hold, 1);
        measure(n, seen);
        chk(n == 6, "R8 test-step hold length", n, 6);
        chk(seen == 1, "R9 expiry at hold end", seen, 1);
    endtask

    task automatic t_station_hd;
        fd = 0;
        pause(STA, 16'd9);
        exp_cnt = bump(exp_cnt);
        chk(got_rx == 1, "R1 R6 half duplex irq", got_rx, 1);
        chk(got_hold == 0, "R7 half duplex no hold", got_hold, 0);
        chk(got_cnt == exp_cnt, "R11", got_cnt, exp_cnt);
        repeat (12) @(negedge clk);
        chk(tx_hold == 0, "R7", tx_hold, 0);
        fd = 1;
    endtask

    task automatic t_rejects;
        pause(48'h01_80_C2_00_00_02, 16'd4);   expect_none("R1 wrong DA");
        send(GRP, 16'h8809, 16'h0001, 16'd4, 60, -1, 0, 1); expect_none("R2 type");
        send(GRP, 16'h8808, 16'h0101, 16'd4, 60, -1, 0, 1); expect_none("R2 opcode");
        send(GRP, 16'h8808, 16'h0001, 16'd4, 60, 30, 0, 1);  expect_none("R3 error beat");
        pfc = 1; pause(GRP, 16'd4); pfc = 0;   expect_none("R4 pfc");
        send(GRP, 16'h8808, 16'h0001, 16'd4, 17, -1, 0, 1);  expect_none("R5 short");
        send(GRP, 16'h8808, 16'h0001, 16'd4, 14, -1, 0, 0);
        send(GRP, 16'h8808, 16'h0001, 16'd4, 6, -1, 14, 1);  expect_none("R5 restart");
    endtask

    task automatic t_min_len;
        int n; bit seen;
        send(GRP, 16'h8808, 16'h0001, 16'h0102, 18, -1, 0, 1);
        exp_cnt = bump(exp_cnt);
        chk(got_rx == 1, "R2 R5 18-byte frame", got_rx, 1);
        busy = 1;
        @(negedge clk);
        busy = 0;
        measure(n, seen);
        chk(n == 259, "R2 big-endian quantum", n, 259);
    endtask

    task automatic t_busy_and_overwrite;
        int n; bit seen;
        busy = 1;
        pause(STA, 16'd2);
        exp_cnt = bump(exp_cnt);
        repeat (10) @(negedge clk);
        chk(tx_hold == 1 && irq_exp == 0, "R8 frozen while busy", tx_hold, 1);
        pause(STA, 16'd200);
        exp_cnt = bump(exp_cnt);
        pause(GRP, 16'd3);
        exp_cnt = bump(exp_cnt);
        chk(got_cnt == exp_cnt, "R11", got_cnt, exp_cnt);
        busy = 0;
        measure(n, seen);
        chk(n == 4, "R10 overwrite", n, 4);
        chk(seen == 1, "R9", seen, 1);
    endtask

    task automatic t_slot_tick;
        int n; bit seen;
        tst = 0; tick_en = 1;
        pause(GRP, 16'd2);
        exp_cnt = bump(exp_cnt);
        measure(n, seen);
        chk(n >= 5 && n <= 12, "R8 slot tick pacing", n, 8);
        chk(seen == 1, "R9", seen, 1);
        tst = 1; tick_en = 0;
    endtask

    task automatic t_zero;
        busy = 1;
        pause(GRP, 16'd50);
        exp_cnt = bump(exp_cnt);
        pause(GRP, 16'd0);
        exp_cnt = bump(exp_cnt);
        chk(got_exp == 1, "R9 zero quantum irq", got_exp, 1);
        chk(got_hold == 0, "R9 zero quantum clears hold", got_hold, 0);
        busy = 0;
        msk = 0;
        pause(GRP, 16'd0);
        exp_cnt = bump(exp_cnt);
        chk(got_rx == 1 && got_exp == 0, "R9 masked", got_exp, 0);
        msk = 1;
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 9; k++) begin
            pause(GRP, 16'd0);
            exp_cnt = bump(exp_cnt);
        end
        chk(got_cnt == (1 << CW) - 1, "R11 saturation", got_cnt, (1 << CW) - 1);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_group_fd;
        t_station_hd;
        t_rejects;
        t_min_len;
        t_busy_and_overwrite;
        t_slot_tick;
        t_zero;
        t_saturate;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule